// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low handshake lines from a modem: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line is synchronized into the core clock domain. The block reports the current level of every line and a sticky change flag for every line in one 8-bit read-only status word. A change-pending output goes high while any change flag is set, so that downstream interrupt logic can raise a low-priority event. The flags stay set until software reads the status word.

The block also holds a 5-bit modem control word. This word drives data terminal ready, request to send, two general-purpose outputs and a loopback enable. All pin outputs are active-low. In loopback, the control bits are routed internally onto the status lines in place of the external pins, which gives a self-test path that never touches the line. The control pins are held inactive while loopback is on.

Top module: `modem_status_ctl`

## Requirements
- R1: Status bits [7:4] show, in that order, the active-high level of carrier detect, ring indicator, data-set-ready and clear-to-send. Each bit is the complement of its pin. A pin change is visible in the status word after the second rising clock edge following the change.
- R2: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set on either edge of their line. Each bit sets one clock after the level bit changes.
- R3: Status bit 2 sets only when the ring indicator pin goes from low to high (line asserted to released). A pin going from high to low leaves it clear.
- R4: Change flags hold until the status word is read. A read is rd_en_i high with addr_i = 1 at a rising edge, and it clears all four flags at that edge. A read with addr_i = 0 clears nothing.
- R5: An edge that is detected at the same rising edge as a status read leaves its flag set after that read.
- R6: change_o is high exactly when at least one of status bits [3:0] is set.
- R7: A write (wr_en_i high, addr_i = 0) stores wdata_i[4:0] as the control word. Reading with addr_i = 0 returns that word in bits [4:0], with bits [7:5] reading 0.
- R8: Outside loopback, dtr_no, rts_no, out1_no and out2_no are the complements of control bits 0, 1, 2 and 3. loop_o equals control bit 4.
- R9: With control bit 4 set, the external status pins have no effect. Request to send feeds clear-to-send, data terminal ready feeds data-set-ready, output 1 feeds the ring indicator and output 2 feeds carrier detect. All four control pins are driven high (inactive).
- R10: After reset, with all pins high, the status word, the control word and change_o are all 0, and the control pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (status read clears flags) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| dcd_ni | input | 1 | Carrier detect pin, active low |
| dtr_no | output | 1 | Data terminal ready, active low |
| rts_no | output | 1 | Request to send, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2, active low |
| loop_o | output | 1 | Loopback enable |
| change_o | output | 1 | Any change flag set |

## Verification
The hardest case to reach is a line edge that is detected at exactly the rising edge where software reads and clears the flags. The bench gets there by counting the synchronizer and detector stages. It first latches a clear-to-send flag. It then changes data-set-ready and raises the read strobe so that the read lands on the third edge after the pin change. The old flag must clear and the new flag must stay set. All 256 ordered pairs of pin patterns are swept to cover both-edge and trailing-only detection. Loopback is swept through all 16 control patterns while the external pins are toggled.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned REG_W     = 8;

  // line index inside the status nibbles
  typedef enum int unsigned {
    LN_CTS = 0,
    LN_DSR = 1,
    LN_RI  = 2,
    LN_DCD = 3
  } line_e;

  // control word bit positions
  typedef enum int unsigned {
    CB_DTR  = 0,
    CB_RTS  = 1,
    CB_OUT1 = 2,
    CB_OUT2 = 3,
    CB_LOOP = 4
  } ctrl_bit_e;

  // lines that flag only on release (level 1 -> 0)
  localparam logic [NUM_LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
  parameter int unsigned W         = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic        RST_VAL   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/msc_delta.sv
module msc_delta #(
  parameter int unsigned          N          = 4,
  parameter logic [N-1:0]         TRAIL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic         clr_i,
  output logic [N-1:0] delta_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    if (TRAIL_MASK[i]) begin : g_trail
      assign edge_w[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign edge_w[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  // new edges win over a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delta_o <= '0;
    else         delta_o <= (delta_o & {N{~clr_i}}) | edge_w;
  end
endmodule

// File: rtl/msc_ctrl.sv
module msc_ctrl
  import msc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              out1_no,
  output logic              out2_no,
  output logic              loop_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;
  assign loop_o = ctrl_q[CB_LOOP];

  // pins parked inactive during loopback
  assign dtr_no  = ctrl_q[CB_LOOP] | ~ctrl_q[CB_DTR];
  assign rts_no  = ctrl_q[CB_LOOP] | ~ctrl_q[CB_RTS];
  assign out1_no = ctrl_q[CB_LOOP] | ~ctrl_q[CB_OUT1];
  assign out2_no = ctrl_q[CB_LOOP] | ~ctrl_q[CB_OUT2];
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
  import msc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             dcd_ni,
  output logic             dtr_no,
  output logic             rts_no,
  output logic             out1_no,
  output logic             out2_no,
  output logic             loop_o,
  output logic             change_o
);
  localparam int unsigned PAD_W = REG_W - CTRL_W;

  logic [CTRL_W-1:0]    ctrl_w;
  logic [NUM_LINES-1:0] pin_n_w, loop_n_w, src_n_w, sync_n_w, lvl_w, delta_w;
  logic [REG_W-1:0]     status_w;
  logic                 stat_rd_w, ctrl_we_w;

  assign ctrl_we_w = wr_en_i & ~addr_i;
  assign stat_rd_w = rd_en_i & addr_i;

  msc_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_w),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl_w),
    .dtr_no  (dtr_no),
    .rts_no  (rts_no),
    .out1_no (out1_no),
    .out2_no (out2_no),
    .loop_o  (loop_o)
  );

  assign pin_n_w[LN_CTS] = cts_ni;
  assign pin_n_w[LN_DSR] = dsr_ni;
  assign pin_n_w[LN_RI]  = ri_ni;
  assign pin_n_w[LN_DCD] = dcd_ni;

  assign loop_n_w[LN_CTS] = ~ctrl_w[CB_RTS];
  assign loop_n_w[LN_DSR] = ~ctrl_w[CB_DTR];
  assign loop_n_w[LN_RI]  = ~ctrl_w[CB_OUT1];
  assign loop_n_w[LN_DCD] = ~ctrl_w[CB_OUT2];

  assign src_n_w = ctrl_w[CB_LOOP] ? loop_n_w : pin_n_w;

  msc_sync #(.W(NUM_LINES), .STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_n_w),
    .q_o    (sync_n_w)
  );

  assign lvl_w = ~sync_n_w;

  msc_delta #(.N(NUM_LINES), .TRAIL_MASK(TRAIL_ONLY)) i_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl_w),
    .clr_i   (stat_rd_w),
    .delta_o (delta_w)
  );

  assign status_w = {lvl_w, delta_w};
  assign change_o = |delta_w;
  assign rdata_o  = addr_i ? status_w : {{PAD_W{1'b0}}, ctrl_w};
endmodule

// File: rtl/msc_checker.sv
module msc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] status_i,
  input logic       change_o,
  input logic       loop_o,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       out1_no,
  input logic       out2_no
);
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i) |=> (status_i[3:0] == 4'd0) ||
      ($past(status_i[7:4], 1) != $past(status_i[7:4], 2))); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i) |=> (($past(status_i[3:0]) & ~status_i[3:0]) == 4'd0)); // R4
  AST_RING_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[2]) |-> ($past(status_i[6], 2) && !$past(status_i[6], 1))); // R3
  AST_CHANGE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(change_o) |-> ($past(status_i[7:4], 1) != $past(status_i[7:4], 2))); // R6
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> (loop_o == $past(wdata_i[4]))); // R7
  AST_LOOP_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_o |-> (dtr_no && rts_no && out1_no && out2_no)); // R9
endmodule

bind modem_status_ctl msc_checker i_msc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .wdata_i  (wdata_i),
  .status_i (status_w),
  .change_o (change_o),
  .loop_o   (loop_o),
  .dtr_no   (dtr_no),
  .rts_no   (rts_no),
  .out1_no  (out1_no),
  .out2_no  (out2_no)
);

// File: tb/test_modem_status_ctl.sv
module test_modem_status_ctl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] pins_n = 4'hF; // [0] cts [1] dsr [2] ri [3] dcd
  logic       dtr_no, rts_no, out1_no, out2_no, loop_o, change_o;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  modem_status_ctl i_modem_status_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata),
    .cts_ni(pins_n[0]), .dsr_ni(pins_n[1]), .ri_ni(pins_n[2]), .dcd_ni(pins_n[3]),
    .dtr_no(dtr_no), .rts_no(rts_no), .out1_no(out1_no), .out2_no(out2_no),
    .loop_o(loop_o), .change_o(change_o)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic status_read();
    addr = 1'b1; rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic ctrl_write(logic [7:0] v);
    addr = 1'b0; wr_en = 1'b1; wdata = v; tick(); wr_en = 1'b0; addr = 1'b1;
  endtask

  function automatic logic [3:0] loop_lvl(logic [3:0] v);
    return {v[3], v[2], v[0], v[1]};
  endfunction

  function automatic logic [3:0] delta_of(logic [3:0] pl, logic [3:0] nl);
    logic [3:0] d = pl ^ nl;
    d[2] = pl[2] & ~nl[2];
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick();
    // R10 reset state
    addr = 1'b1; #1; check("R10 status", rdata, 8'h00);
    check("R10 change", {7'd0, change_o}, 8'h00);
    addr = 1'b0; #1; check("R10 ctrl", rdata, 8'h00);
    check("R10 pins", {4'd0, dtr_no, rts_no, out1_no, out2_no}, 8'h0F);
    addr = 1'b1;

    // R1 R2 R3 R4 R6: every ordered pair of pin patterns
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] pa = 4'(a), pb = 4'(b), d;
        pins_n = pa; tick(3); status_read();
        check("R4 cleared", {4'd0, rdata[3:0]}, 8'h00);
        pins_n = pb; tick(3);
        d = delta_of(~pa, ~pb);
        check("R1 R2 R3 status", rdata, {~pb, d});
        check("R6 change", {7'd0, change_o}, {7'd0, |d});
        addr = 1'b0; rd_en = 1'b1; tick(); rd_en = 1'b0; addr = 1'b1;
        check("R4 ctrl read keeps flags", {4'd0, rdata[3:0]}, {4'd0, d});
        status_read();
        check("R4 read clears", rdata, {~pb, 4'd0});
        check("R6 change low", {7'd0, change_o}, 8'h00);
      end
    end

    // R5 edge coinciding with a read
    pins_n = 4'hF; tick(3); status_read();
    pins_n = 4'hE; tick(3);
    check("R5 setup", {4'd0, rdata[3:0]}, 8'h01);
    pins_n = 4'hC; tick(2);
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    check("R5 new edge kept", {4'd0, rdata[3:0]}, 8'h02);
    status_read(); pins_n = 4'hF; tick(3); status_read();

    // R7 R8 control word and pins
    for (int v = 0; v < 16; v++) begin
      logic [3:0] cv = 4'(v);
      ctrl_write({3'b111, 1'b0, cv});
      addr = 1'b0; #1;
      check("R7 readback", rdata, {4'd0, cv});
      check("R8 pins", {3'd0, loop_o, dtr_no, rts_no, out1_no, out2_no},
            {3'd0, 1'b0, ~cv[0], ~cv[1], ~cv[2], ~cv[3]});
      addr = 1'b1;
    end

    // R9 loopback sweep with pin toggling
    ctrl_write(8'h10); tick(3); status_read();
    begin
      logic [3:0] pl = 4'd0;
      for (int v = 0; v < 16; v++) begin
        logic [3:0] cv = 4'(v), nl;
        nl = loop_lvl(cv);
        ctrl_write({3'd0, 1'b1, cv}); tick(3);
        check("R9 loop status", rdata, {nl, delta_of(pl, nl)});
        check("R9 pins inactive", {3'd0, loop_o, dtr_no, rts_no, out1_no, out2_no}, 8'h1F);
        status_read();
        pins_n = ~pins_n ^ cv; tick(4);
        check("R9 pins ignored", rdata, {nl, 4'd0});
        pl = nl;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule